// File: doc/BRIEF.md
# Multi-Channel Gamma Lookup Table

This block applies gamma correction for several display channels (three by default) that share one table store. Every channel owns three 256-entry, 8-bit tables, one for each colour component. On each cycle a channel can present one pixel. When its gamma enable is set, each 8-bit component is replaced by the entry it selects in that channel's table for the same colour. When the enable is clear, the component passes through unchanged. Both paths take exactly one cycle.

A host fills the tables through a two-location register port. The index register holds a 12-bit table index and two control bits: auto-advance and force-on. The data location writes one byte at that index. A whole channel loads with one index write followed by 768 data writes. When no channel has gamma enabled and force-on is clear, the store is treated as powered down. Writes are then dropped, and all contents are lost until the host reloads them.

Top module: `gamma_lut`

## Requirements
- R1: The flat table index of an entry is channel × 768 + colour × 256 + component value, with colour 0 = red, 1 = green and 2 = blue. The default configuration has 2304 valid indices.
- R2: A host write with `host_sel`=0 loads the index register: bits [11:0] give the index, bit 31 auto-advance and bit 30 force-on. With `host_rd_sel`=0, `host_rdata` returns {auto-advance, force-on, 18 zero bits, index}.
- R3: A host write with `host_sel`=1 stores bits [7:0] at the current index. If auto-advance is set, the index then rises by one and wraps from 4095 to 0; otherwise it stays unchanged. With `host_rd_sel`=1, `host_rdata` returns the entry at the current index, zero-extended.
- R4: Data writes at an index of 2304 or above change no entry, and a table read there returns zero. Auto-advance still moves the index.
- R5: For a channel with gamma enabled, each output component one cycle later equals its table entry, and `pix_vld_o` repeats `pix_vld_i` one cycle later.
- R6: For a channel with gamma disabled, each output component one cycle later equals the input component, with the same one-cycle valid delay.
- R7: The store is on when any gamma enable is set or force-on is set. While it is off, data writes change neither any entry nor the index. Force-on alone keeps writes working with every channel disabled.
- R8: After any cycle in which the store was off, every entry reads as zero, both from the host port and through an enabled channel, until it is written again.
- R9: When a data write and a pixel lookup hit the same entry in the same cycle, the pixel output carries the value held before the write.
- R10: After reset, all valid outputs are low, the index register reads zero, and every entry reads zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host write strobe |
| host_sel | input | 1 | Write target: 0 index register, 1 data location |
| host_wdata | input | 32 | Host write data |
| host_rd_sel | input | 1 | Read source: 0 index register, 1 entry at current index |
| host_rdata | output | 32 | Host read data (combinational) |
| gamma_en | input | NCH | Per-channel gamma enable |
| pix_vld_i | input | NCH | Per-channel pixel valid in |
| pix_r_i | input | NCH*8 | Red components, channel c at [8c+7:8c] |
| pix_g_i | input | NCH*8 | Green components |
| pix_b_i | input | NCH*8 | Blue components |
| pix_vld_o | output | NCH | Pixel valid out, one cycle later |
| pix_r_o | output | NCH*8 | Corrected red |
| pix_g_o | output | NCH*8 | Corrected green |
| pix_b_o | output | NCH*8 | Corrected blue |

## Verification
All tables are filled with seeded random bytes, so a wrong channel or colour offset gives a wrong byte rather than a plausible identity value. Marker bytes placed at single entries check that each channel, colour and component value reaches its own entry. Random gamma-enable masks, including all-clear ones, are mixed with pixel traffic and host writes. This tells table lookup apart from bypass, and it catches lost contents after each power-down. Directed cases cover a write and a lookup hitting the same entry, out-of-range indices, index wrap, and force-on with every channel disabled.

// File: rtl/gamma_lut.sv
module gamma_lut #(
  parameter int NCH = 3,
  parameter int DW  = 8,
  parameter int IW  = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic              host_sel,
  input  logic [31:0]       host_wdata,
  input  logic              host_rd_sel,
  output logic [31:0]       host_rdata,
  input  logic [NCH-1:0]    gamma_en,
  input  logic [NCH-1:0]    pix_vld_i,
  input  logic [NCH*DW-1:0] pix_r_i,
  input  logic [NCH*DW-1:0] pix_g_i,
  input  logic [NCH*DW-1:0] pix_b_i,
  output logic [NCH-1:0]    pix_vld_o,
  output logic [NCH*DW-1:0] pix_r_o,
  output logic [NCH*DW-1:0] pix_g_o,
  output logic [NCH*DW-1:0] pix_b_o
);
  localparam int ENTRIES = 1 << DW;
  localparam int TBL     = 3 * ENTRIES;
  localparam int DEPTH   = NCH * TBL;

  logic [IW-1:0]    idx;
  logic             autoinc, force_on;
  logic [DW-1:0]    mem [DEPTH];
  logic [DEPTH-1:0] vld;
  logic [DW-1:0]    lr [NCH];
  logic [DW-1:0]    lg [NCH];
  logic [DW-1:0]    lb [NCH];
  logic [DW-1:0]    tbl_rd;

  wire mem_on   = (|gamma_en) | force_on;
  wire in_range = int'(idx) < DEPTH;
  wire addr_wr  = host_wr & ~host_sel;
  wire data_wr  = host_wr & host_sel;

  function automatic logic [DW-1:0] look(input int a);
    return vld[a] ? mem[a] : '0;
  endfunction

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      idx      <= '0;
      autoinc  <= 1'b0;
      force_on <= 1'b0;
    end else if (addr_wr) begin
      idx      <= host_wdata[IW-1:0];
      autoinc  <= host_wdata[31];
      force_on <= host_wdata[30];
    end else if (data_wr && mem_on && autoinc) begin
      idx <= idx + 1'b1;
    end
  end

  always_ff @(posedge clk)
    if (data_wr && mem_on && in_range) mem[idx] <= host_wdata[DW-1:0];

  always_ff @(posedge clk) begin
    if (!rst_n || !mem_on) vld <= '0;
    else if (data_wr && in_range) vld[idx] <= 1'b1;
  end

  assign tbl_rd = (mem_on && in_range) ? look(int'(idx)) : '0;
  assign host_rdata = host_rd_sel ? {{(32-DW){1'b0}}, tbl_rd}
                                  : {autoinc, force_on, {(30-IW){1'b0}}, idx};

  always_comb begin
    for (int c = 0; c < NCH; c++) begin
      lr[c] = gamma_en[c] ? look(c*TBL + int'(pix_r_i[c*DW +: DW]))
                          : pix_r_i[c*DW +: DW];
      lg[c] = gamma_en[c] ? look(c*TBL + ENTRIES + int'(pix_g_i[c*DW +: DW]))
                          : pix_g_i[c*DW +: DW];
      lb[c] = gamma_en[c] ? look(c*TBL + 2*ENTRIES + int'(pix_b_i[c*DW +: DW]))
                          : pix_b_i[c*DW +: DW];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pix_vld_o <= '0;
      pix_r_o   <= '0;
      pix_g_o   <= '0;
      pix_b_o   <= '0;
    end else begin
      pix_vld_o <= pix_vld_i;
      for (int c = 0; c < NCH; c++) begin
        pix_r_o[c*DW +: DW] <= lr[c];
        pix_g_o[c*DW +: DW] <= lg[c];
        pix_b_o[c*DW +: DW] <= lb[c];
      end
    end
  end

  // R2
  idx_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    addr_wr |=> (idx == $past(host_wdata[IW-1:0])) && (autoinc == $past(host_wdata[31])));
  // R3
  autoinc_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && mem_on && autoinc) |=> idx == $past(idx) + 1'b1);
  // R3
  idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !autoinc) |=> $stable(idx));
  // R7
  off_idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_wr && !mem_on) |=> $stable(idx));
  // R8
  lost_contents_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_on |=> vld == '0);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !gamma_en[c] |=> (pix_r_o[c*DW +: DW] == $past(pix_r_i[c*DW +: DW])) &&
                       (pix_b_o[c*DW +: DW] == $past(pix_b_i[c*DW +: DW])));
    // R5
    valid_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pix_vld_i[c] |=> pix_vld_o[c]);
  end
endmodule

// File: tb/gamma_lut_test.sv
`timescale 1ns/1ps
module gamma_lut_test;
  localparam int NCH = 3;
  localparam int DEPTH = NCH * 768;

  logic clk = 0, rst_n = 0;
  logic host_wr = 0, host_sel = 0, host_rd_sel = 0;
  logic [31:0] host_wdata = 0;
  logic [31:0] host_rdata;
  logic [NCH-1:0] gamma_en = 0, pix_vld_i = 0, pix_vld_o;
  logic [NCH*8-1:0] pix_r_i = 0, pix_g_i = 0, pix_b_i = 0;
  logic [NCH*8-1:0] pix_r_o, pix_g_o, pix_b_o;

  int n_cmp = 0, n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  gamma_lut #(.NCH(NCH)) uut (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_sel(host_sel),
    .host_wdata(host_wdata), .host_rd_sel(host_rd_sel), .host_rdata(host_rdata),
    .gamma_en(gamma_en), .pix_vld_i(pix_vld_i), .pix_r_i(pix_r_i),
    .pix_g_i(pix_g_i), .pix_b_i(pix_b_i), .pix_vld_o(pix_vld_o),
    .pix_r_o(pix_r_o), .pix_g_o(pix_g_o), .pix_b_o(pix_b_o));

  logic [7:0] mem_m [DEPTH];
  bit vld_m [DEPTH];
  int idx_m = 0;
  bit ai_m = 0, fo_m = 0, on_m;

  always @(posedge clk) begin
    if (!rst_n) begin
      idx_m = 0; ai_m = 0; fo_m = 0;
      for (int i = 0; i < DEPTH; i++) vld_m[i] = 0;
    end else begin
      on_m = (|gamma_en) || fo_m;
      if (host_wr && !host_sel) begin
        idx_m = int'(host_wdata[11:0]); ai_m = host_wdata[31]; fo_m = host_wdata[30];
      end else if (host_wr && host_sel && on_m) begin
        if (idx_m < DEPTH) begin mem_m[idx_m] = host_wdata[7:0]; vld_m[idx_m] = 1; end
        if (ai_m) idx_m = (idx_m + 1) % 4096;
      end
      if (!on_m) for (int i = 0; i < DEPTH; i++) vld_m[i] = 0;
    end
  end

  function automatic logic [7:0] exp_lut(int c, int col, logic [7:0] v);
    int a = c*768 + col*256 + int'(v);
    return vld_m[a] ? mem_m[a] : 8'h00;
  endfunction

  function automatic logic [31:0] exp_rd(bit sel);
    if (!sel) return {ai_m, fo_m, 18'b0, 12'(idx_m)};
    if (!((|gamma_en) || fo_m) || idx_m >= DEPTH || !vld_m[idx_m]) return 0;
    return {24'b0, mem_m[idx_m]};
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic cycle();
    logic [7:0] er[NCH], eg[NCH], eb[NCH];
    logic [NCH-1:0] ev = pix_vld_i;
    logic [NCH-1:0] en = gamma_en;
    for (int c = 0; c < NCH; c++) begin
      er[c] = en[c] ? exp_lut(c, 0, pix_r_i[c*8 +: 8]) : pix_r_i[c*8 +: 8];
      eg[c] = en[c] ? exp_lut(c, 1, pix_g_i[c*8 +: 8]) : pix_g_i[c*8 +: 8];
      eb[c] = en[c] ? exp_lut(c, 2, pix_b_i[c*8 +: 8]) : pix_b_i[c*8 +: 8];
    end
    @(posedge clk); @(negedge clk);
    host_wr = 0;
    for (int c = 0; c < NCH; c++) begin
      chk(en[c] ? "R5 valid" : "R6 valid", {31'b0, pix_vld_o[c]}, {31'b0, ev[c]});
      chk(en[c] ? "R5 pixel" : "R6 pixel",
          {8'b0, pix_r_o[c*8 +: 8], pix_g_o[c*8 +: 8], pix_b_o[c*8 +: 8]},
          {8'b0, er[c], eg[c], eb[c]});
    end
  endtask

  task automatic wr(bit sel, logic [31:0] d);
    host_wr = 1; host_sel = sel; host_wdata = d;
    cycle();
  endtask

  task automatic rdchk(string req, bit sel, logic [31:0] exp);
    host_rd_sel = sel; #0.5;
    chk(req, host_rdata, exp);
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [7:0] old;
    int unsigned seed;
    seed = $urandom(32'd20240613);
    repeat (3) @(posedge clk);
    @(negedge clk);
    // R10 during reset
    chk("R10 valid", {29'b0, pix_vld_o}, 0);
    rdchk("R10 index", 0, 0);
    rst_n = 1;
    @(negedge clk);
    rdchk("R10 index", 0, 0);
    gamma_en = 3'b111;
    rdchk("R10 table", 1, 0);

    wr(0, 32'hC000_0005);
    rdchk("R2 readback", 0, 32'hC000_0005);

    wr(0, 32'h8000_0000);
    for (int i = 0; i < DEPTH; i++) wr(1, $urandom & 32'hFF);
    rdchk("R3 advance", 0, 32'h8000_0000 | DEPTH);

    // R1 markers: ch1 green 77, ch2 blue 200
    wr(0, 768 + 256 + 77);  wr(1, 32'h1A5);
    rdchk("R3 no advance", 0, 768 + 256 + 77);
    rdchk("R3 table read", 1, 32'hA5);
    wr(0, 2*768 + 512 + 200); wr(1, 32'h3C);
    pix_vld_i = 3'b110;
    pix_g_i = {8'd0, 8'd77, 8'd0}; pix_b_i = {8'd200, 8'd0, 8'd0};
    cycle();
    chk("R1 ch1 green", {24'b0, pix_g_o[15:8]}, 32'hA5);
    chk("R1 ch2 blue", {24'b0, pix_b_o[23:16]}, 32'h3C);

    // R4
    wr(0, 32'h8000_0000 | DEPTH);
    rdchk("R4 read high", 1, 0);
    wr(1, 32'hFF);
    rdchk("R4 advance", 0, 32'h8000_0000 | (DEPTH + 1));
    wr(0, 32'h8000_0000 | DEPTH);
    rdchk("R4 not stored", 1, 0);
    wr(0, 32'h8000_0FFF); wr(1, 32'h11);
    rdchk("R3 wrap", 0, 32'h8000_0000);

    // R9
    wr(0, 10);
    old = mem_m[10];
    gamma_en = 3'b001; pix_vld_i = 3'b001; pix_r_i = 24'd10;
    host_wr = 1; host_sel = 1; host_wdata = 32'h55;
    cycle();
    chk("R9 old value", {24'b0, pix_r_o[7:0]}, {24'b0, old});
    cycle();
    chk("R9 new value", {24'b0, pix_r_o[7:0]}, 32'h55);

    // R7 / R8
    wr(0, 32'h8000_000A);
    gamma_en = 0;
    cycle();
    wr(1, 32'h77);
    rdchk("R7 index held", 0, 32'h8000_000A);
    gamma_en = 3'b001;
    rdchk("R8 lost", 1, 0);
    cycle();
    chk("R8 pixel zero", {24'b0, pix_r_o[7:0]}, 0);
    gamma_en = 0;
    wr(0, 32'h4000_0014); wr(1, 32'h99);
    rdchk("R7 force on", 1, 32'h99);
    pix_r_i = 24'hABCDEF;
    cycle();
    chk("R6 bypass", {8'b0, pix_r_o}, 32'h00ABCDEF);

    // random mix
    for (int k = 0; k < 3000; k++) begin
      int r = $urandom % 100;
      gamma_en = ($urandom % 10 == 0) ? 3'b000 : 3'($urandom);
      pix_vld_i = 3'($urandom);
      pix_r_i = 24'($urandom); pix_g_i = 24'($urandom); pix_b_i = 24'($urandom);
      if (r < 60) begin
        host_wr = 1; host_sel = 1; host_wdata = $urandom;
      end else if (r < 66) begin
        host_wr = 1; host_sel = 0;
        host_wdata = {1'b1, ($urandom % 8 == 0), 18'b0, 12'($urandom % DEPTH)};
      end
      if (k % 16 == 0) begin
        rdchk("R3 random read", 1, exp_rd(1));
        rdchk("R2 random read", 0, exp_rd(0));
      end
      cycle();
    end
    summary();
  end
endmodule